// File: doc/BRIEF.md
# Channel-Status Audio Stream Formatter

This block turns a flow of multichannel PCM samples into a 32-bit audio stream with valid/ready handshaking. Each output beat carries one sample. The beat also carries the channel number on its ID lane, a 4-bit preamble code that marks the position of the beat in the block, and one bit of a 192-bit channel-status word. Frame k of a 192-frame block carries status bit k. The block tracks the channel index within a frame and the frame index within a block, and it restarts both whenever it is disabled.

Software writes the channel-status word through a word-wide write port and sets the number of channels per frame. It then raises `enable`. Both values are captured at that rising edge, so later writes take effect only at the next enable. After reset, or after any disable, `enable` must be seen low before a rising edge starts the stream.

Top module: `chs_stream_fmt`

## Requirements
- R1: After reset the block stays idle (`m_tvalid` and `smp_ready` low) even when `enable` is held high throughout reset. Streaming starts only after `enable` has been sampled low and then high.
- R2: While `enable` is low, `m_tvalid` and `smp_ready` are low from the next clock edge on, and any held beat is dropped. The next start resumes at channel 0 of frame 0.
- R3: A beat transfers only on an edge where `m_tvalid` and `m_tready` are both high. While `m_tready` is low, `m_tvalid`, `m_tdata` and `m_tid` hold their values.
- R4: `m_tid` counts 0, 1, …, N-1 over the beats of a frame and then wraps to 0, where N is the channel count in force.
- R5: The data word carries the preamble in bits [3:0], the 24-bit sample in bits [27:4] and the status bit in bit 30. Bits 31, 29 and 28 are zero.
- R6: The preamble is 4'h1 on channel 0 of frame 0, 4'h2 on every other even-numbered channel and 4'h3 on every odd-numbered channel.
- R7: Frame k (0 to 191) carries status bit k, which is bit k mod 32 of the word written at address k div 32 (addresses 0 to 5). After frame 191 the block restarts at frame 0.
- R8: The status word is captured when streaming starts. Writes made while streaming do not change the output until the next start.
- R9: The channel count is sampled from `cfg_nchan` when streaming starts. Values below 2 are treated as 2 and values above 32 as 32.
- R10: Each accepted sample produces exactly one beat, in arrival order. `smp_ready` is low while a beat is held unaccepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control; its rising edge captures the configuration |
| cfg_nchan | input | 6 | Channels per frame, sampled at start |
| cs_wr_en | input | 1 | Status-word write strobe |
| cs_wr_addr | input | 3 | Index of the 32-bit status word being written |
| cs_wr_data | input | 32 | Status-word write data |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample accepted on this edge if valid |
| smp_data | input | 24 | PCM sample |
| m_tdata | output | 32 | Formatted beat |
| m_tvalid | output | 1 | Beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tid | output | 5 | Channel number of the beat |

## Verification
The hardest case to reach is the block boundary: frame 191 going to frame 0 while a status word differs from the live register contents. The stimulus starts a run and rewrites all six status words mid-stream. It then keeps going past a full block so that every frame index is compared against the captured word, not the new one. A second hard case is a disable that lands while a beat is stalled by backpressure. The bench holds `m_tready` low with a beat pending, drops `enable`, and checks that the next start begins cleanly with the block-start code.

// File: rtl/chs_pkg.sv
package chs_pkg;

    typedef enum logic [3:0] {
        PRE_NONE  = 4'h0,
        PRE_BLOCK = 4'h1,
        PRE_CH_A  = 4'h2,
        PRE_CH_B  = 4'h3
    } pre_code_e;

    localparam int BEAT_W     = 32;
    localparam int PRE_LSB    = 0;
    localparam int SAMPLE_LSB = 4;
    localparam int STATUS_BIT = 30;

endpackage

// File: rtl/chs_cfg_bank.sv
module chs_cfg_bank #(
    parameter int FRAMES = 192,
    parameter int WORD_W = 32,
    parameter int ADDR_W = 3,
    parameter int FR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              capture,
    input  logic [FR_W-1:0]   frame_idx,
    output logic              status_bit
);

    typedef struct packed {
        logic [FRAMES-1:0] live;
        logic [FRAMES-1:0] held;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < FRAMES; i++) begin
            if (wr_en && (wr_addr == ADDR_W'(i / WORD_W))) begin
                bank_d.live[i] = wr_data[i % WORD_W];
            end
        end
        if (capture) begin
            bank_d.held = bank_q.live;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign status_bit = bank_q.held[frame_idx];

endmodule

// File: rtl/chs_pos_track.sv
module chs_pos_track #(
    parameter int FRAMES = 192,
    parameter int CH_W   = 5,
    parameter int FR_W   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    input  logic [CH_W-1:0] last_ch,
    output logic [CH_W-1:0] chan,
    output logic [FR_W-1:0] frame
);

    typedef struct packed {
        logic [CH_W-1:0] chan;
        logic [FR_W-1:0] frame;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (clear) begin
            pos_d = '0;
        end else if (step) begin
            if (pos_q.chan == last_ch) begin
                pos_d.chan  = '0;
                pos_d.frame = (pos_q.frame == FR_W'(FRAMES - 1)) ? '0
                                                                  : pos_q.frame + 1'b1;
            end else begin
                pos_d.chan = pos_q.chan + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign chan  = pos_q.chan;
    assign frame = pos_q.frame;

endmodule

// File: rtl/chs_beat_pack.sv
module chs_beat_pack
    import chs_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int CH_W     = 5
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [CH_W-1:0]     chan,
    input  logic                first_frame,
    input  logic                status_bit,
    output logic [BEAT_W-1:0]   beat
);

    pre_code_e pre;

    always_comb begin
        if (first_frame && (chan == '0)) begin
            pre = PRE_BLOCK;
        end else if (chan[0]) begin
            pre = PRE_CH_B;
        end else begin
            pre = PRE_CH_A;
        end
        beat                            = '0;
        beat[PRE_LSB +: 4]              = pre;
        beat[SAMPLE_LSB +: SAMPLE_W]    = sample;
        beat[STATUS_BIT]                = status_bit;
    end

endmodule

// File: rtl/chs_stream_fmt.sv
module chs_stream_fmt
    import chs_pkg::*;
#(
    parameter int  FRAMES   = 192,
    parameter int  SAMPLE_W = 24,
    parameter int  MAX_CH   = 32,
    parameter int  CFG_W    = 32,
    localparam int FR_W     = $clog2(FRAMES),
    localparam int CH_W     = $clog2(MAX_CH),
    localparam int NWORDS   = FRAMES / CFG_W,
    localparam int ADDR_W   = $clog2(NWORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [CH_W:0]       cfg_nchan,
    input  logic                cs_wr_en,
    input  logic [ADDR_W-1:0]   cs_wr_addr,
    input  logic [CFG_W-1:0]    cs_wr_data,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic [BEAT_W-1:0]   m_tdata,
    output logic                m_tvalid,
    input  logic                m_tready,
    output logic [CH_W-1:0]     m_tid
);

    typedef struct packed {
        logic              en_prev;
        logic              running;
        logic [CH_W-1:0]   last_ch;
        logic              tvalid;
        logic [BEAT_W-1:0] tdata;
        logic [CH_W-1:0]   tid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              start;
    logic              out_free;
    logic              accept;
    logic [CH_W-1:0]   cur_chan;
    logic [FR_W-1:0]   cur_frame;
    logic              cur_status;
    logic [BEAT_W-1:0] new_beat;
    logic [CH_W-1:0]   clamped_last;

    assign start    = enable && !ctl_q.en_prev;
    assign out_free = !ctl_q.tvalid || m_tready;
    assign smp_ready = ctl_q.running && enable && out_free;
    assign accept   = smp_ready && smp_valid;

    always_comb begin
        if (cfg_nchan < (CH_W+1)'(2)) begin
            clamped_last = CH_W'(1);
        end else if (cfg_nchan > (CH_W+1)'(MAX_CH)) begin
            clamped_last = CH_W'(MAX_CH - 1);
        end else begin
            clamped_last = CH_W'(cfg_nchan - 1'b1);
        end
    end

    chs_cfg_bank #(
        .FRAMES (FRAMES),
        .WORD_W (CFG_W),
        .ADDR_W (ADDR_W),
        .FR_W   (FR_W)
    ) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cs_wr_en),
        .wr_addr    (cs_wr_addr),
        .wr_data    (cs_wr_data),
        .capture    (start),
        .frame_idx  (cur_frame),
        .status_bit (cur_status)
    );

    chs_pos_track #(
        .FRAMES (FRAMES),
        .CH_W   (CH_W),
        .FR_W   (FR_W)
    ) pos_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!enable),
        .step    (accept),
        .last_ch (ctl_q.last_ch),
        .chan    (cur_chan),
        .frame   (cur_frame)
    );

    chs_beat_pack #(
        .SAMPLE_W (SAMPLE_W),
        .CH_W     (CH_W)
    ) pack_i (
        .sample      (smp_data),
        .chan        (cur_chan),
        .first_frame (cur_frame == '0),
        .status_bit  (cur_status),
        .beat        (new_beat)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.en_prev = enable;
        ctl_d.running = enable && (ctl_q.running || start);
        if (start) begin
            ctl_d.last_ch = clamped_last;
        end
        if (!enable) begin
            ctl_d.tvalid = 1'b0;
        end else if (accept) begin
            ctl_d.tvalid = 1'b1;
            ctl_d.tdata  = new_beat;
            ctl_d.tid    = cur_chan;
        end else if (m_tready) begin
            ctl_d.tvalid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.en_prev <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign m_tvalid = ctl_q.tvalid;
    assign m_tdata  = ctl_q.tdata;
    assign m_tid    = ctl_q.tid;

endmodule

// File: rtl/chs_stream_fmt_chk.sv
module chs_stream_fmt_chk #(
    parameter int CH_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            smp_ready,
    input logic [31:0]     m_tdata,
    input logic            m_tvalid,
    input logic            m_tready,
    input logic [CH_W-1:0] m_tid
);

    // R2
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!m_tvalid && !smp_ready));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && m_tvalid && !m_tready) ##1 enable |->
            (m_tvalid && $stable(m_tdata) && $stable(m_tid)));

    // R10
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> (!m_tvalid || m_tready));

    // R5
    spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tdata[31] == 1'b0 && m_tdata[29:28] == 2'b00));

    // R6
    pre_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tdata[3:0] != 4'h0 && m_tdata[3:0] <= 4'h3));

    // R6
    block_on_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tdata[3:0] == 4'h1) |-> (m_tid == '0));

    // R6
    odd_is_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && m_tid[0]) |-> (m_tdata[3:0] == 4'h3));

endmodule

bind chs_stream_fmt chs_stream_fmt_chk #(.CH_W(CH_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .smp_ready (smp_ready),
    .m_tdata   (m_tdata),
    .m_tvalid  (m_tvalid),
    .m_tready  (m_tready),
    .m_tid     (m_tid)
);

// File: tb/chs_stream_fmt_tb.sv
module chs_stream_fmt_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic [5:0]  cfg_nchan = 6'd2;
    logic        cs_wr_en = 1'b0;
    logic [2:0]  cs_wr_addr = '0;
    logic [31:0] cs_wr_data = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic [23:0] smp_data = '0;
    logic [31:0] m_tdata;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic [4:0]  m_tid;

    int checks = 0;
    int errors = 0;

    logic          drv_on = 1'b0;
    logic          bp_mode = 1'b0;
    logic          acc_pend = 1'b0;
    logic [15:0]   lfsr = 16'hACE1;
    logic          prev_stall = 1'b0;
    logic [31:0]   prev_data = '0;
    logic [4:0]    prev_tid = '0;
    int            exp_frame = 0;
    int            exp_ch = 0;
    int            exp_nch = 2;
    int            exp_idx = 0;
    logic [23:0]   seed = 24'h000100;
    logic [191:0]  cs_exp = '0;

    always #5 clk = ~clk;

    chs_stream_fmt dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cfg_nchan  (cfg_nchan),
        .cs_wr_en   (cs_wr_en),
        .cs_wr_addr (cs_wr_addr),
        .cs_wr_data (cs_wr_data),
        .smp_valid  (smp_valid),
        .smp_ready  (smp_ready),
        .smp_data   (smp_data),
        .m_tdata    (m_tdata),
        .m_tvalid   (m_tvalid),
        .m_tready   (m_tready),
        .m_tid      (m_tid)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] cs_word(input int w, input int salt);
        return (32'h9E3779B9 * (w + salt + 1)) ^ (32'h1 << (w * 5 + salt));
    endfunction

    function automatic logic [191:0] cs_vec(input int salt);
        logic [191:0] v;
        for (int k = 0; k < 192; k++) begin
            logic [31:0] w;
            w = cs_word(k / 32, salt);
            v[k] = w[k % 32];
        end
        return v;
    endfunction

    // Driver and output monitor
    always @(negedge clk) begin
        if (drv_on) begin
            if (acc_pend) smp_data = smp_data + 24'd1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            smp_valid = bp_mode ? (lfsr[1] | lfsr[4]) : 1'b1;
            m_tready  = bp_mode ? (lfsr[2] | lfsr[7]) : 1'b1;
            #1;
            acc_pend = smp_valid && smp_ready;
            if (prev_stall) begin
                chk(m_tvalid && m_tdata == prev_data && m_tid == prev_tid,
                    "R3", "held beat", m_tdata, prev_data);
            end
            if (m_tvalid && !m_tready) begin
                chk(!smp_ready, "R10", "ready while stalled", 32'(smp_ready), 32'd0);
            end
            prev_stall = m_tvalid && !m_tready;
            prev_data  = m_tdata;
            prev_tid   = m_tid;
            if (m_tvalid && m_tready) begin
                logic [3:0] pre;
                pre = (exp_frame == 0 && exp_ch == 0) ? 4'h1 : ((exp_ch % 2) != 0 ? 4'h3 : 4'h2);
                chk(m_tid == 5'(exp_ch), "R4", "tid", 32'(m_tid), 32'(exp_ch));
                chk(m_tdata[3:0] == pre, "R6", "preamble", 32'(m_tdata[3:0]), 32'(pre));
                chk(m_tdata[27:4] == seed + 24'(exp_idx), "R10", "sample order",
                    32'(m_tdata[27:4]), 32'(seed + 24'(exp_idx)));
                chk(m_tdata[30] == cs_exp[exp_frame], "R7", "status bit",
                    32'(m_tdata[30]), 32'(cs_exp[exp_frame]));
                chk(m_tdata[31] == 1'b0 && m_tdata[29:28] == 2'b00, "R5", "spare bits",
                    m_tdata, 32'(m_tdata & 32'h4FFF_FFFF));
                exp_idx++;
                if (exp_ch == exp_nch - 1) begin
                    exp_ch = 0;
                    exp_frame = (exp_frame + 1) % 192;
                end else begin
                    exp_ch++;
                end
            end
        end
    end

    task automatic write_cs(input int salt);
        for (int w = 0; w < 6; w++) begin
            @(negedge clk);
            cs_wr_en   = 1'b1;
            cs_wr_addr = 3'(w);
            cs_wr_data = cs_word(w, salt);
        end
        @(negedge clk);
        cs_wr_en = 1'b0;
    endtask

    task automatic start_run(input int nch_cfg, input int nch_exp, input int salt,
                             input logic do_write);
        drv_on = 1'b0;
        @(negedge clk);
        smp_valid = 1'b0;
        m_tready  = 1'b1;
        enable    = 1'b0;
        if (do_write) write_cs(salt);
        cfg_nchan = 6'(nch_cfg);
        @(negedge clk);
        @(negedge clk);
        exp_frame  = 0;
        exp_ch     = 0;
        exp_idx    = 0;
        exp_nch    = nch_exp;
        cs_exp     = cs_vec(salt);
        seed       = seed + 24'h010000;
        smp_data   = seed;
        acc_pend   = 1'b0;
        prev_stall = 1'b0;
        enable     = 1'b1;
        drv_on     = 1'b1;
    endtask

    task automatic run_beats(input int n);
        int target;
        target = exp_idx + n;
        while (exp_idx < target) @(negedge clk);
    endtask

    task automatic t_reset_idle;
        smp_valid = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!m_tvalid, "R1", "tvalid after reset", 32'(m_tvalid), 32'd0);
        chk(!smp_ready, "R1", "ready with enable held", 32'(smp_ready), 32'd0);
        start_run(2, 2, 0, 1'b1);
        repeat (3) @(negedge clk);
        chk(exp_idx > 0, "R1", "stream after re-enable", 32'(exp_idx), 32'd1);
    endtask

    task automatic t_two_ch_blocks;
        start_run(2, 2, 1, 1'b1);
        run_beats(2 * 192 * 2 + 10);
        chk(exp_frame == 5, "R7", "frame wrap count", 32'(exp_frame), 32'd5);
    endtask

    task automatic t_status_capture;
        start_run(2, 2, 2, 1'b1);
        run_beats(100);
        write_cs(3);
        run_beats(400);
        start_run(2, 2, 3, 1'b0);
        run_beats(400);
        chk(1'b1, "R8", "capture runs done", 32'd1, 32'd1);
    endtask

    task automatic t_channel_counts;
        start_run(5, 5, 4, 1'b1);
        run_beats(1000);
        start_run(40, 32, 5, 1'b1);
        run_beats(200);
        start_run(0, 2, 6, 1'b1);
        run_beats(50);
        start_run(1, 2, 7, 1'b1);
        run_beats(10);
        chk(exp_nch == 2, "R9", "clamp low", 32'(exp_nch), 32'd2);
    endtask

    task automatic t_backpressure;
        bp_mode = 1'b1;
        start_run(3, 3, 8, 1'b1);
        run_beats(600);
        bp_mode = 1'b0;
    endtask

    task automatic t_disable_mid;
        start_run(2, 2, 9, 1'b1);
        run_beats(51);
        drv_on = 1'b0;
        @(negedge clk);
        m_tready  = 1'b0;
        smp_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(m_tvalid, "R3", "beat held under stall", 32'(m_tvalid), 32'd1);
        enable = 1'b0;
        @(negedge clk);
        chk(!m_tvalid, "R2", "tvalid after disable", 32'(m_tvalid), 32'd0);
        chk(!smp_ready, "R2", "ready after disable", 32'(smp_ready), 32'd0);
        start_run(2, 2, 9, 1'b0);
        run_beats(6);
        chk(exp_frame == 3, "R2", "restart from frame 0", 32'(exp_frame), 32'd3);
    endtask

    initial begin
        t_reset_idle();
        t_two_ch_blocks();
        t_status_capture();
        t_channel_counts();
        t_backpressure();
        t_disable_mid();
        drv_on = 1'b0;
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule